// File: doc/BRIEF.md
# EDO DRAM Strobe Cycle Classifier

This block watches the control strobes of an extended-data-out DRAM bus. It samples the row strobe, the two per-byte column strobes, write enable and output enable once per clock, with all strobes active low. From the order of their edges it names each memory operation: a read, an early write or a read-modify-write for every column access, and a RAS-only, CAS-before-RAS, self or hidden refresh for row-strobe cycles that carry no normal access. For each column access it also reports the byte lanes that were used and the access's position within the open row. It also tracks the interval during which the memory drives the data pins, and raises an error pulse for strobe sequences that break the protocol.

The block fits as a passive bus monitor or as the control front end of a memory model. The classification leaves as a one-cycle event: `op_valid` qualifies `op_code`, `op_lanes` and `op_index`. There is no ready input. The block cannot hold back the bus it observes, so a consumer must take every pulse in the cycle it appears, and two events are never adjacent. `dq_drive` and `proto_err` are plain level and pulse outputs.

Top module: `edo_cycle_decoder`

## Requirements
- R1: After reset, `op_valid`, `dq_drive` and `proto_err` are low and stay low while the bus idles (all strobes high).
- R2: A column access opens when a column strobe goes low while the row strobe is low in a normal row cycle. It closes at the first sample where both column strobes are high or the row strobe has risen. One cycle after the closing sample, `op_code` reports one of three values: 1 (read) if write enable was high at opening and never fell, 2 (early write) if write enable was low at opening, or 3 (read-modify-write) if it was high at opening and fell while the access was open.
- R3: `op_lanes` bit 0 is the lower byte and bit 1 is the upper byte. For an access, it is the OR of the lanes active over every open sample, so it is never zero. For refresh codes it is zero.
- R4: `op_index` numbers the column accesses of one row-strobe low period 0, 1, 2, … in order. It restarts at each row-strobe fall and saturates at its maximum. It is zero for refresh codes.
- R5: A row-strobe low period that opened with both column strobes high and held no column access reports code 4 one cycle after the sample where the row strobe rises. The data pins are not driven.
- R6: If a column strobe is low in the sample before the row strobe falls and is still low when it falls (and no hidden-refresh condition applies), the period reports code 5 at the row rise. It reports code 6 instead if a column strobe stayed low throughout and the row strobe was low for at least `SELF_CYC` samples.
- R7: If a column access is still open when the row strobe rises, and the row strobe falls again while a column strobe stays low, that period reports code 7 at its row rise. `dq_drive` stays high throughout.
- R8: An access opening with write enable high and output enable low raises `dq_drive` from the next cycle. An access opening with write enable low leaves it low.
- R9: `dq_drive` falls after a sample with the row strobe and both column strobes high, or with output enable high, or with write enable low. It stays high when only the column strobes rise while the row strobe remains low.
- R10: `proto_err` pulses for one cycle in two cases: after the `RAS_MAX+1`-th consecutive row-low sample, except in CAS-before-RAS and self-refresh periods, and after a column strobe goes low and back high while the row strobe stays high.
- R11: `op_valid` is a single-cycle pulse and is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| ucas_n | input | 1 | Upper-byte column strobe, active low |
| lcas_n | input | 1 | Lower-byte column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| op_valid | output | 1 | One-cycle event qualifier |
| op_code | output | 4 | Operation code (1–7, see R2, R5–R7) |
| op_lanes | output | 2 | Byte lanes of the access |
| op_index | output | IDX_W | Access number within the row |
| dq_drive | output | 1 | Memory is driving the data pins |
| proto_err | output | 1 | Protocol error pulse |

## Verification
The assertions assume that the strobes are already synchronous to `clk` and change at most once per sample. They also assume an idle bus with every strobe high at reset release, so the first edge seen is a real one. The stimulus meets this by driving every strobe on the falling clock edge from a single task. It starts from the idle bus, and it lets each row-strobe low period end before the next begins. Refresh patterns, page bursts and the two error shapes are applied as whole sequences, so no unintended edge appears between them.

// File: rtl/edo_dec_pkg.sv
package edo_dec_pkg;
  localparam int LANES = 2;

  typedef enum logic [3:0] {
    OP_NONE   = 4'd0,
    OP_READ   = 4'd1,
    OP_EWRITE = 4'd2,
    OP_RMW    = 4'd3,
    OP_ROR    = 4'd4,
    OP_CBR    = 4'd5,
    OP_SELF   = 4'd6,
    OP_HIDDEN = 4'd7
  } op_e;

  typedef enum logic [1:0] {RM_IDLE, RM_ROW, RM_CBR, RM_HIDDEN} rmode_e;

  typedef struct packed {
    logic ras_fall;
    logic ras_rise;
    logic cas_open;
    logic cas_close;
    logic we_fall;
  } strobe_ev_t;

  typedef struct packed {
    logic             ras_lo;
    logic             cas_lo;
    logic             p_cas_lo;
    logic             we_lo;
    logic             oe_lo;
    logic [LANES-1:0] lanes;
  } strobe_lvl_t;
endpackage

// File: rtl/edo_strobe_edges.sv
module edo_strobe_edges
  import edo_dec_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ras_n,
  input  logic        ucas_n,
  input  logic        lcas_n,
  input  logic        we_n,
  input  logic        oe_n,
  output strobe_ev_t  ev,
  output strobe_lvl_t lv
);
  logic [LANES-1:0] cas_n_vec;
  logic [LANES-1:0] lane_act;
  logic p_ras_lo, p_cas_lo, p_we_lo;

  assign cas_n_vec = {ucas_n, lcas_n};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_act[g] = ~cas_n_vec[g];
  end

  assign lv.ras_lo   = ~ras_n;
  assign lv.cas_lo   = |lane_act;
  assign lv.p_cas_lo = p_cas_lo;
  assign lv.we_lo    = ~we_n;
  assign lv.oe_lo    = ~oe_n;
  assign lv.lanes    = lane_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_ras_lo <= 1'b0;
      p_cas_lo <= 1'b0;
      p_we_lo  <= 1'b0;
    end else begin
      p_ras_lo <= lv.ras_lo;
      p_cas_lo <= lv.cas_lo;
      p_we_lo  <= lv.we_lo;
    end
  end

  assign ev.ras_fall  = lv.ras_lo & ~p_ras_lo;
  assign ev.ras_rise  = ~lv.ras_lo & p_ras_lo;
  assign ev.cas_open  = lv.cas_lo & ~p_cas_lo;
  assign ev.cas_close = ~lv.cas_lo & p_cas_lo;
  assign ev.we_fall   = lv.we_lo & ~p_we_lo;
endmodule

// File: rtl/edo_ras_timer.sv
module edo_ras_timer #(
  parameter int RAS_MAX  = 1000,
  parameter int SELF_CYC = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_lo,
  input  logic ras_fall,
  input  logic exempt,
  output logic long_low,
  output logic ras_over
);
  localparam int LIM = (RAS_MAX > SELF_CYC) ? RAS_MAX : SELF_CYC;
  localparam int CW  = $clog2(LIM + 2);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (ras_fall)             cnt <= CW'(1);
    else if (ras_lo && cnt != '1)  cnt <= cnt + CW'(1);
    else if (!ras_lo)              cnt <= '0;
  end

  assign long_low = (cnt >= CW'(SELF_CYC));
  assign ras_over = ras_lo & ~ras_fall & (cnt == CW'(RAS_MAX)) & ~exempt;
endmodule

// File: rtl/edo_cycle_classifier.sv
module edo_cycle_classifier
  import edo_dec_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_ev_t       ev,
  input  strobe_lvl_t      lv,
  input  logic             long_low,
  input  logic             ras_over,
  output logic             row_open,
  output logic             cbr_now,
  output logic             op_valid,
  output op_e              op_code,
  output logic [LANES-1:0] op_lanes,
  output logic [IDX_W-1:0] op_index,
  output logic             proto_err
);
  rmode_e           mode, mode_now;
  logic             held, pend, kept;
  logic             acc_open, acc_seen, acc_ew, acc_rmw;
  logic [LANES-1:0] acc_lanes;
  logic [IDX_W-1:0] idx;
  logic             close, ras_op, pre_err;
  op_e              acc_code, ras_code;

  always_comb begin
    mode_now = mode;
    if (ev.ras_fall) begin
      if (held && lv.cas_lo)             mode_now = RM_HIDDEN;
      else if (lv.p_cas_lo && lv.cas_lo) mode_now = RM_CBR;
      else                               mode_now = RM_ROW;
    end
  end

  assign row_open = ev.cas_open & lv.ras_lo & (mode_now == RM_ROW);
  assign cbr_now  = (mode_now == RM_CBR);
  assign close    = acc_open & (ev.cas_close | ev.ras_rise);
  assign ras_op   = ev.ras_rise & (mode != RM_IDLE) & ((mode != RM_ROW) | ~acc_seen);
  assign pre_err  = ev.cas_close & ~lv.ras_lo & pend;
  assign acc_code = acc_ew ? OP_EWRITE : (acc_rmw ? OP_RMW : OP_READ);

  always_comb begin
    case (mode)
      RM_HIDDEN: ras_code = OP_HIDDEN;
      RM_CBR:    ras_code = (long_low && kept) ? OP_SELF : OP_CBR;
      default:   ras_code = OP_ROR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= RM_IDLE;
      held      <= 1'b0;
      pend      <= 1'b0;
      kept      <= 1'b0;
      acc_open  <= 1'b0;
      acc_seen  <= 1'b0;
      acc_ew    <= 1'b0;
      acc_rmw   <= 1'b0;
      acc_lanes <= '0;
      idx       <= '0;
      op_valid  <= 1'b0;
      op_code   <= OP_NONE;
      op_lanes  <= '0;
      op_index  <= '0;
      proto_err <= 1'b0;
    end else begin
      op_valid  <= close | ras_op;
      op_code   <= close ? acc_code : (ras_op ? ras_code : OP_NONE);
      op_lanes  <= close ? acc_lanes : '0;
      op_index  <= close ? idx : '0;
      proto_err <= ras_over | pre_err;

      if (ev.ras_fall)      mode <= mode_now;
      else if (ev.ras_rise) mode <= RM_IDLE;

      if (!lv.cas_lo) held <= 1'b0;
      else if (ev.ras_rise && (acc_open || mode == RM_HIDDEN)) held <= 1'b1;

      if (ev.ras_fall || !lv.cas_lo) pend <= 1'b0;
      else if (ev.cas_open && !lv.ras_lo && !held) pend <= 1'b1;

      if (ev.ras_fall)    kept <= 1'b1;
      else if (!lv.cas_lo) kept <= 1'b0;

      if (ev.ras_fall)               idx <= '0;
      else if (close && idx != '1)   idx <= idx + IDX_W'(1);

      if (row_open)         acc_seen <= 1'b1;
      else if (ev.ras_fall) acc_seen <= 1'b0;

      if (row_open)   acc_open <= 1'b1;
      else if (close) acc_open <= 1'b0;

      if (row_open) begin
        acc_ew    <= lv.we_lo;
        acc_rmw   <= 1'b0;
        acc_lanes <= lv.lanes;
      end else if (acc_open && !close) begin
        if (ev.we_fall && !acc_ew) acc_rmw <= 1'b1;
        acc_lanes <= acc_lanes | lv.lanes;
      end
    end
  end
endmodule

// File: rtl/edo_dq_window.sv
module edo_dq_window (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_lo,
  input  logic cas_lo,
  input  logic we_lo,
  input  logic oe_lo,
  input  logic row_open,
  output logic dq_drive
);
  logic drive_nxt;

  always_comb begin
    drive_nxt = dq_drive;
    if (!ras_lo && !cas_lo)  drive_nxt = 1'b0;
    else if (row_open)       drive_nxt = ~we_lo & oe_lo;
    else if (!oe_lo || we_lo) drive_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dq_drive <= 1'b0;
    else        dq_drive <= drive_nxt;
  end
endmodule

// File: rtl/edo_cycle_decoder.sv
module edo_cycle_decoder
  import edo_dec_pkg::*;
#(
  parameter int RAS_MAX  = 1000,
  parameter int SELF_CYC = 400,
  parameter int IDX_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic             ucas_n,
  input  logic             lcas_n,
  input  logic             we_n,
  input  logic             oe_n,
  output logic             op_valid,
  output logic [3:0]       op_code,
  output logic [1:0]       op_lanes,
  output logic [IDX_W-1:0] op_index,
  output logic             dq_drive,
  output logic             proto_err
);
  strobe_ev_t  ev;
  strobe_lvl_t lv;
  logic        long_low, ras_over, row_open, cbr_now;
  op_e         code_q;

  edo_strobe_edges u_edges (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n),
    .we_n(we_n), .oe_n(oe_n), .ev(ev), .lv(lv)
  );

  edo_ras_timer #(.RAS_MAX(RAS_MAX), .SELF_CYC(SELF_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .ras_lo(lv.ras_lo), .ras_fall(ev.ras_fall),
    .exempt(cbr_now), .long_low(long_low), .ras_over(ras_over)
  );

  edo_cycle_classifier #(.IDX_W(IDX_W)) u_class (
    .clk(clk), .rst_n(rst_n), .ev(ev), .lv(lv), .long_low(long_low),
    .ras_over(ras_over), .row_open(row_open), .cbr_now(cbr_now),
    .op_valid(op_valid), .op_code(code_q), .op_lanes(op_lanes),
    .op_index(op_index), .proto_err(proto_err)
  );

  edo_dq_window u_dq (
    .clk(clk), .rst_n(rst_n), .ras_lo(lv.ras_lo), .cas_lo(lv.cas_lo),
    .we_lo(lv.we_lo), .oe_lo(lv.oe_lo), .row_open(row_open), .dq_drive(dq_drive)
  );

  assign op_code = code_q;
endmodule

// File: rtl/edo_cycle_decoder_chk.sv
module edo_cycle_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ras_n,
  input logic       ucas_n,
  input logic       lcas_n,
  input logic       we_n,
  input logic       oe_n,
  input logic       op_valid,
  input logic [3:0] op_code,
  input logic [1:0] op_lanes,
  input logic       dq_drive
);
  // R11
  op_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> !op_valid);

  // R3
  access_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code >= 4'd1 && op_code <= 4'd3) |-> (op_lanes != 2'b00));

  // R5
  refresh_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code >= 4'd4) |-> (op_lanes == 2'b00 && $past(ras_n)));

  // R9
  dq_idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n && ucas_n && lcas_n) |=> !dq_drive);

  // R9
  dq_oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |=> !dq_drive);

  // R8
  dq_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_drive) |-> ($past(we_n) && !$past(oe_n) && !$past(ras_n)));
endmodule

bind edo_cycle_decoder edo_cycle_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n),
  .we_n(we_n), .oe_n(oe_n), .op_valid(op_valid), .op_code(op_code),
  .op_lanes(op_lanes), .dq_drive(dq_drive)
);

// File: tb/edo_cycle_decoder_tb.sv
`timescale 1ns/1ps
module edo_cycle_decoder_tb;
  localparam int IDX_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, ucas_n = 1'b1, lcas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic             op_valid, dq_drive, proto_err;
  logic [3:0]       op_code;
  logic [1:0]       op_lanes;
  logic [IDX_W-1:0] op_index;

  int checks = 0;
  int errs = 0;
  int err_seen = 0;
  logic prev_valid = 1'b0;
  logic [9:0] sbq[$];
  string      tagq[$];

  always #10 clk = ~clk;

  edo_cycle_decoder #(.RAS_MAX(40), .SELF_CYC(16), .IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n),
    .we_n(we_n), .oe_n(oe_n), .op_valid(op_valid), .op_code(op_code),
    .op_lanes(op_lanes), .op_index(op_index), .dq_drive(dq_drive),
    .proto_err(proto_err)
  );

  task automatic tick(input logic r, input logic u, input logic l,
                      input logic w, input logic o);
    @(negedge clk);
    ras_n = r; ucas_n = u; lcas_n = l; we_n = w; oe_n = o;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_op(input int code, input int lanes, input int idx, input string tag);
    sbq.push_back({4'(code), 2'(lanes), 4'(idx)});
    tagq.push_back(tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (proto_err) err_seen++;
      if (op_valid) begin
        checks++;
        if (prev_valid) begin
          errs++;
          $display("FAIL R11 actual=back-to-back expected=single pulse");
        end
        if (sbq.size() == 0) begin
          errs++;
          $display("FAIL R2 actual=op %0d expected=no op", op_code);
        end else begin
          logic [9:0] e;
          string      t;
          e = sbq.pop_front();
          t = tagq.pop_front();
          if ({op_code, op_lanes, op_index} != e) begin
            errs++;
            $display("FAIL %s actual=code%0d/lanes%0d/idx%0d expected=code%0d/lanes%0d/idx%0d",
                     t, op_code, op_lanes, op_index, e[9:6], e[5:4], e[3:0]);
          end
        end
      end
      prev_valid <= op_valid;
    end
  end

  initial begin
    #(200000 * 20);
    errs++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick(1,1,1,1,1); tick(1,1,1,1,1);
    chk("R1 op_valid", op_valid, 0);
    chk("R1 dq_drive", dq_drive, 0);
    chk("R1 proto_err", proto_err, 0);

    // page-mode row: word read, lower early write, upper RMW, growing lanes
    tick(0,1,1,1,0);
    tick(0,0,0,1,0);
    tick(0,0,0,1,0); chk("R8 read drives", dq_drive, 1);
    tick(0,1,1,1,0); expect_op(1, 3, 0, "R2 word read R4 idx0");
    tick(0,1,0,0,0); chk("R9 EDO hold after column rise", dq_drive, 1);
    tick(0,1,0,0,0); chk("R8 early write no drive", dq_drive, 0);
    tick(0,1,1,1,0); expect_op(2, 1, 1, "R2 early write R3 lower R4 idx1");
    tick(0,0,1,1,0);
    tick(0,0,1,1,0); chk("R8 upper read drives", dq_drive, 1);
    tick(0,0,1,0,0);
    tick(0,0,1,0,0); chk("R9 WE low stops drive", dq_drive, 0);
    tick(0,1,1,1,0); expect_op(3, 2, 2, "R2 RMW R3 upper R4 idx2");
    tick(0,1,0,1,0);
    tick(0,0,0,1,0);
    tick(0,1,1,1,0); expect_op(1, 3, 3, "R3 lane OR R4 idx3");
    tick(1,1,1,1,0);
    tick(1,1,1,1,1); chk("R9 idle bus off", dq_drive, 0);

    // RAS-only refresh
    tick(0,1,1,1,1); tick(0,1,1,1,1); tick(0,1,1,1,1);
    tick(1,1,1,1,1); expect_op(4, 0, 0, "R5 RAS-only");
    tick(1,1,1,1,1); chk("R5 no drive", dq_drive, 0);

    // CAS-before-RAS, column released early
    tick(1,0,0,1,1);
    tick(0,0,0,1,1); tick(0,0,0,1,1);
    tick(0,1,1,1,1); tick(0,1,1,1,1);
    tick(1,1,1,1,1); expect_op(5, 0, 0, "R6 CBR");
    tick(1,1,1,1,1);

    // self refresh, lower strobe only, longer than RAS_MAX (exempt)
    tick(1,1,0,1,1);
    for (int i = 0; i < 45; i++) tick(0,1,0,1,1);
    tick(1,1,1,1,1); expect_op(6, 0, 0, "R6 self refresh");
    tick(1,1,1,1,1);

    // hidden refresh after a word read
    tick(1,1,1,1,0);
    tick(0,1,1,1,0);
    tick(0,0,0,1,0);
    tick(0,0,0,1,0); chk("R8 read drives", dq_drive, 1);
    tick(1,0,0,1,0); expect_op(1, 3, 0, "R2 read closed by row rise");
    tick(1,0,0,1,0); chk("R7 drive across row rise", dq_drive, 1);
    tick(0,0,0,1,0);
    tick(0,0,0,1,0);
    tick(0,0,0,1,0); chk("R7 drive during hidden", dq_drive, 1);
    tick(1,0,0,1,0); expect_op(7, 0, 0, "R7 hidden");
    tick(1,1,1,1,0);
    tick(1,1,1,1,0); chk("R9 off after last rise", dq_drive, 0);

    // row strobe held too long
    for (int i = 0; i < 40; i++) tick(0,1,1,1,1);
    tick(0,1,1,1,1); chk("R10 no error at limit", proto_err, 0);
    tick(1,1,1,1,1); chk("R10 over-long row", proto_err, 1);
    expect_op(4, 0, 0, "R5 RAS-only after long row");
    tick(1,1,1,1,1); chk("R10 single pulse", proto_err, 0);

    // column pulse during precharge
    tick(1,1,0,1,1);
    tick(1,1,1,1,1);
    tick(1,1,1,1,1); chk("R10 precharge pulse", proto_err, 1);

    repeat (4) tick(1,1,1,1,1);
    chk("R2 scoreboard drained", sbq.size(), 0);
    chk("R10 total error pulses", err_seen, 2);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule